// File: doc/BRIEF.md
# Masked packed narrowing converter

This block narrows a vector of 32-bit integer lanes into 16-bit lanes. Each lane is narrowed in one of three ways: the high half is dropped, the lane is clamped as a signed value, or it is clamped as an unsigned value. The vector length sets how many lanes take part: 4, 8 or 16. A per-lane mask chooses which lanes receive a new result. A lane that is not chosen either keeps the old destination contents or is cleared.

An execution stage drives one operation per `valid_i` pulse. The registered result appears on the next clock together with `valid_o`. When the destination is a register, the result is zero-extended to the full 512-bit register width. When the destination is memory, per-lane byte enables show which lanes a store unit should write. A reserved operand field, an unused mode code or an unused length code makes the block flag the operation as illegal, and nothing is written.

Top module: `narrow_conv`

## Requirements
- R1: `vlen_i` sets the lane count: 2'b00 gives 4 lanes, 2'b01 gives 8 lanes and 2'b10 gives 16 lanes. Every result bit at or above 16 times the lane count reads zero.
- R2: Output lane j occupies `result_o[16j+15:16j]` and is computed from `src_i[32j+31:32j]`.
- R3: With `mode_i` = 2'b00, a written lane takes the low 16 bits of its source lane.
- R4: With `mode_i` = 2'b01, a written lane takes its source lane as two's complement, clamped to -32768..32767 (16'h8000..16'h7FFF).
- R5: With `mode_i` = 2'b10, a written lane takes its source lane as unsigned, clamped to at most 65535 (16'hFFFF).
- R6: An active lane is written when `mask_en_i` is 0, or when `mask_en_i` is 1 and `mask_i[j]` is 1.
- R7: With a register destination (`dst_mem_i` = 0), an active lane that is not written takes `old_i[16j+15:16j]` when `zero_mode_i` = 0 and reads zero when `zero_mode_i` = 1.
- R8: With a memory destination (`dst_mem_i` = 1), a lane that is not written always takes its `old_i` value, whatever `zero_mode_i` is. Its two byte-enable bits `byte_en_o[2j+1:2j]` are 2'b00. A written active lane has 2'b11.
- R9: With a register destination, `byte_en_o` is all zero.
- R10: `illegal_o` is 1 when `rsvd_i` is not 4'b1111, when `mode_i` is 2'b11, or when `vlen_i` is 2'b11. In that case `result_o` and `byte_en_o` are all zero.
- R11: The outputs are updated on the clock edge that samples `valid_i` = 1, and `valid_o` is 1 for that single cycle. When `valid_i` is 0, the outputs hold their values. `rst_ni` low clears all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Operation strobe |
| src_i | input | 512 | Source vector, 16 lanes of 32 bits |
| old_i | input | 256 | Old destination contents, 16 lanes of 16 bits |
| mask_i | input | 16 | Per-lane write mask |
| mask_en_i | input | 1 | Mask enable |
| zero_mode_i | input | 1 | 1: clear unwritten register lanes, 0: merge |
| dst_mem_i | input | 1 | 1: memory destination, 0: register |
| vlen_i | input | 2 | Vector length code |
| mode_i | input | 2 | Narrowing mode code |
| rsvd_i | input | 4 | Reserved operand field, must be all ones |
| valid_o | output | 1 | Result valid |
| result_o | output | 512 | Narrowed, zero-extended result |
| byte_en_o | output | 32 | Byte enables for a memory store |
| illegal_o | output | 1 | Illegal operation flag |

## Verification
The saturating modes are driven with the values that sit on either side of each clamp boundary (16'h7FFF/16'h8000, 0xFFFF/0x10000, the largest negative value and -1). This separates an off-by-one clamp, and a sign test made on the wrong bit, from correct behaviour. Truncation uses the same vectors, so a mode swap changes the result. Lane-distinct patterns in all three lengths show up a wrong lane slice or a wrong zero-fill limit. Sparse masks are applied under merge, under zeroing and to memory, so the merge, zero and byte-enable paths each change a different lane. Each of the three illegal causes is applied on its own.

// File: rtl/narrow_pkg.sv
package narrow_pkg;
  typedef enum logic [1:0] {
    CVT_TRUNC = 2'b00,
    CVT_SSAT  = 2'b01,
    CVT_USAT  = 2'b10,
    CVT_BAD   = 2'b11
  } cvt_mode_e;

  typedef enum logic [1:0] {
    VL_SHORT = 2'b00,
    VL_MID   = 2'b01,
    VL_LONG  = 2'b10,
    VL_BAD   = 2'b11
  } vlen_e;
endpackage

// File: rtl/narrow_ctrl.sv
module narrow_ctrl import narrow_pkg::*; #(
  parameter int LANES_MAX = 16,
  parameter int RSVD_W    = 4
) (
  input  logic [1:0]           vlen_i,
  input  logic [1:0]           mode_i,
  input  logic [RSVD_W-1:0]    rsvd_i,
  output logic [LANES_MAX-1:0] lane_act_o,
  output logic                 illegal_o
);
  localparam int LANES_MIN = LANES_MAX / 4;

  always_comb begin
    for (int j = 0; j < LANES_MAX; j++) begin
      lane_act_o[j] = (vlen_i != VL_BAD) && (j < (LANES_MIN << vlen_i));
    end
  end

  assign illegal_o = (rsvd_i != {RSVD_W{1'b1}}) || (mode_i == CVT_BAD) || (vlen_i == VL_BAD);
endmodule

// File: rtl/narrow_lane.sv
module narrow_lane import narrow_pkg::*; #(
  parameter int SRC_W = 32,
  parameter int DST_W = 16
) (
  input  logic [SRC_W-1:0] src_i,
  input  logic [DST_W-1:0] old_i,
  input  logic [1:0]       mode_i,
  input  logic             act_i,
  input  logic             write_i,
  input  logic             keep_old_i,
  input  logic             kill_i,
  output logic [DST_W-1:0] res_o
);
  localparam logic [DST_W-1:0] S_MAX = {1'b0, {(DST_W-1){1'b1}}};
  localparam logic [DST_W-1:0] S_MIN = {1'b1, {(DST_W-1){1'b0}}};

  logic [DST_W-1:0] conv;
  logic             s_fits;
  logic             u_over;

  // signed value fits when the bits above the result sign are all copies of it
  assign s_fits = (&src_i[SRC_W-1:DST_W-1]) || ~(|src_i[SRC_W-1:DST_W-1]);
  assign u_over = |src_i[SRC_W-1:DST_W];

  always_comb begin
    unique case (mode_i)
      CVT_SSAT: conv = s_fits ? src_i[DST_W-1:0] : (src_i[SRC_W-1] ? S_MIN : S_MAX);
      CVT_USAT: conv = u_over ? {DST_W{1'b1}} : src_i[DST_W-1:0];
      default:  conv = src_i[DST_W-1:0];
    endcase
  end

  always_comb begin
    if (kill_i || !act_i) res_o = '0;
    else if (write_i)     res_o = conv;
    else if (keep_old_i)  res_o = old_i;
    else                  res_o = '0;
  end
endmodule

// File: rtl/narrow_mask.sv
module narrow_mask #(
  parameter int LANES_MAX = 16,
  parameter int BE_PER    = 2
) (
  input  logic [LANES_MAX-1:0]        lane_act_i,
  input  logic [LANES_MAX-1:0]        mask_i,
  input  logic                        mask_en_i,
  input  logic                        zero_mode_i,
  input  logic                        dst_mem_i,
  input  logic                        illegal_i,
  output logic [LANES_MAX-1:0]        write_o,
  output logic                        keep_old_o,
  output logic [LANES_MAX*BE_PER-1:0] byte_en_o
);
  assign write_o    = lane_act_i & (mask_en_i ? mask_i : {LANES_MAX{1'b1}});
  // memory targets only merge
  assign keep_old_o = dst_mem_i || !zero_mode_i;

  for (genvar j = 0; j < LANES_MAX; j++) begin : g_be
    assign byte_en_o[j*BE_PER +: BE_PER] = {BE_PER{dst_mem_i && write_o[j] && !illegal_i}};
  end
endmodule

// File: rtl/narrow_conv.sv
module narrow_conv #(
  parameter int SRC_W     = 32,
  parameter int DST_W     = 16,
  parameter int LANES_MAX = 16,
  parameter int REG_W     = 512,
  parameter int RSVD_W    = 4
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            valid_i,
  input  logic [SRC_W*LANES_MAX-1:0]      src_i,
  input  logic [DST_W*LANES_MAX-1:0]      old_i,
  input  logic [LANES_MAX-1:0]            mask_i,
  input  logic                            mask_en_i,
  input  logic                            zero_mode_i,
  input  logic                            dst_mem_i,
  input  logic [1:0]                      vlen_i,
  input  logic [1:0]                      mode_i,
  input  logic [RSVD_W-1:0]               rsvd_i,
  output logic                            valid_o,
  output logic [REG_W-1:0]                result_o,
  output logic [DST_W*LANES_MAX/8-1:0]    byte_en_o,
  output logic                            illegal_o
);
  localparam int DST_VEC_W = DST_W * LANES_MAX;
  localparam int BE_PER    = DST_W / 8;
  localparam int BE_W      = BE_PER * LANES_MAX;

  logic [LANES_MAX-1:0] lane_act;
  logic [LANES_MAX-1:0] write;
  logic                 illegal;
  logic                 keep_old;
  logic [BE_W-1:0]      be_d;
  logic [DST_VEC_W-1:0] res_d;

  logic [DST_VEC_W-1:0] res_q;
  logic [BE_W-1:0]      be_q;
  logic                 ill_q;
  logic                 vld_q;

  narrow_ctrl #(.LANES_MAX(LANES_MAX), .RSVD_W(RSVD_W)) u_ctrl (
    .vlen_i    (vlen_i),
    .mode_i    (mode_i),
    .rsvd_i    (rsvd_i),
    .lane_act_o(lane_act),
    .illegal_o (illegal)
  );

  narrow_mask #(.LANES_MAX(LANES_MAX), .BE_PER(BE_PER)) u_mask (
    .lane_act_i (lane_act),
    .mask_i     (mask_i),
    .mask_en_i  (mask_en_i),
    .zero_mode_i(zero_mode_i),
    .dst_mem_i  (dst_mem_i),
    .illegal_i  (illegal),
    .write_o    (write),
    .keep_old_o (keep_old),
    .byte_en_o  (be_d)
  );

  for (genvar j = 0; j < LANES_MAX; j++) begin : g_lane
    narrow_lane #(.SRC_W(SRC_W), .DST_W(DST_W)) u_lane (
      .src_i     (src_i[j*SRC_W +: SRC_W]),
      .old_i     (old_i[j*DST_W +: DST_W]),
      .mode_i    (mode_i),
      .act_i     (lane_act[j]),
      .write_i   (write[j]),
      .keep_old_i(keep_old),
      .kill_i    (illegal),
      .res_o     (res_d[j*DST_W +: DST_W])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      res_q <= '0;
      be_q  <= '0;
      ill_q <= 1'b0;
    end else begin
      vld_q <= valid_i;
      if (valid_i) begin
        res_q <= res_d;
        be_q  <= be_d;
        ill_q <= illegal;
      end
    end
  end

  assign valid_o   = vld_q;
  assign result_o  = {{(REG_W-DST_VEC_W){1'b0}}, res_q};
  assign byte_en_o = be_q;
  assign illegal_o = ill_q;
endmodule

// File: rtl/narrow_conv_chk.sv
module narrow_conv_chk #(
  parameter int SRC_W     = 32,
  parameter int DST_W     = 16,
  parameter int LANES_MAX = 16,
  parameter int REG_W     = 512,
  parameter int RSVD_W    = 4
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         valid_i,
  input logic [SRC_W*LANES_MAX-1:0]   src_i,
  input logic [DST_W*LANES_MAX-1:0]   old_i,
  input logic [LANES_MAX-1:0]         mask_i,
  input logic                         mask_en_i,
  input logic                         zero_mode_i,
  input logic                         dst_mem_i,
  input logic [1:0]                   vlen_i,
  input logic [1:0]                   mode_i,
  input logic [RSVD_W-1:0]            rsvd_i,
  input logic                         valid_o,
  input logic [REG_W-1:0]             result_o,
  input logic [DST_W*LANES_MAX/8-1:0] byte_en_o,
  input logic                         illegal_o
);
  logic legal_in;
  assign legal_in = (rsvd_i == {RSVD_W{1'b1}}) && (mode_i != 2'b11) && (vlen_i != 2'b11);

  a_r11_valid_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  a_r11_valid_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  a_r11_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(result_o) && $stable(byte_en_o) && $stable(illegal_o)));
  a_r10_rsvd_kill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && rsvd_i != {RSVD_W{1'b1}}) |=> (illegal_o && byte_en_o == '0 && result_o == '0));
  a_r9_reg_no_be: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !dst_mem_i) |=> (byte_en_o == '0));
  a_r1_short_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && vlen_i == 2'b00) |=> (result_o[REG_W-1:4*DST_W] == '0));
  a_r8_mem_merge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && legal_in && dst_mem_i && mask_en_i && !mask_i[0])
      |=> (byte_en_o[1:0] == 2'b00 && result_o[DST_W-1:0] == $past(old_i[DST_W-1:0])));
  a_r7_zero_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && legal_in && !dst_mem_i && zero_mode_i && mask_en_i && !mask_i[0])
      |=> (result_o[DST_W-1:0] == '0));
endmodule

bind narrow_conv narrow_conv_chk #(
  .SRC_W(SRC_W), .DST_W(DST_W), .LANES_MAX(LANES_MAX), .REG_W(REG_W), .RSVD_W(RSVD_W)
) u_chk (.*);

// File: tb/tb_narrow_conv.sv
`timescale 1ns/1ps
module tb_narrow_conv;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         valid = 1'b0;
  logic [511:0] src = '0;
  logic [255:0] old = '0;
  logic [15:0]  mask = '0;
  logic         mask_en = 1'b0;
  logic         zmode = 1'b0;
  logic         mem = 1'b0;
  logic [1:0]   vlen = 2'b10;
  logic [1:0]   mode = 2'b00;
  logic [3:0]   rsvd = 4'hF;
  logic         valid_o;
  logic [511:0] result_o;
  logic [31:0]  byte_en_o;
  logic         illegal_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic [511:0] exp_r;
  logic [31:0]  exp_be;
  logic         exp_ill;

  always #5 clk = ~clk;

  narrow_conv dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .src_i(src), .old_i(old),
    .mask_i(mask), .mask_en_i(mask_en), .zero_mode_i(zmode), .dst_mem_i(mem),
    .vlen_i(vlen), .mode_i(mode), .rsvd_i(rsvd), .valid_o(valid_o),
    .result_o(result_o), .byte_en_o(byte_en_o), .illegal_o(illegal_o)
  );

  task automatic chk(string tag, logic [511:0] got, logic [511:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // expected outputs from the requirements
  task automatic model();
    int   lanes;
    logic [31:0] s;
    logic [15:0] c;
    bit   wr;
    exp_r = '0; exp_be = '0;
    exp_ill = (rsvd != 4'hF) || (mode == 2'b11) || (vlen == 2'b11);
    lanes = (vlen == 2'b00) ? 4 : (vlen == 2'b01) ? 8 : 16;
    if (!exp_ill) begin
      for (int j = 0; j < lanes; j++) begin
        s = src[j*32 +: 32];
        if (mode == 2'b01) begin
          if ($signed(s) > 32767)       c = 16'h7FFF;
          else if ($signed(s) < -32768) c = 16'h8000;
          else                          c = s[15:0];
        end else if (mode == 2'b10) c = (s > 32'd65535) ? 16'hFFFF : s[15:0];
        else c = s[15:0];
        wr = !mask_en || mask[j];
        if (wr) exp_r[j*16 +: 16] = c;
        else if (mem || !zmode) exp_r[j*16 +: 16] = old[j*16 +: 16];
        if (wr && mem) exp_be[j*2 +: 2] = 2'b11;
      end
    end
  endtask

  task automatic run(string tag);
    model();
    valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    valid = 1'b0;
    chk({tag, " valid R11"}, {511'b0, valid_o}, {511'b0, 1'b1});
    chk({tag, " result"}, result_o, exp_r);
    chk({tag, " byte_en"}, {480'b0, byte_en_o}, {480'b0, exp_be});
    chk({tag, " illegal"}, {511'b0, illegal_o}, {511'b0, exp_ill});
  endtask

  task automatic set_corner();
    logic [31:0] v [8] = '{32'h0000_7FFF, 32'h0000_8000, 32'hFFFF_8000, 32'hFFFF_7FFF,
                           32'h8000_0000, 32'h7FFF_FFFF, 32'h0001_0000, 32'hFFFF_FFFF};
    for (int j = 0; j < 16; j++) src[j*32 +: 32] = v[j % 8] ^ (j >= 8 ? 32'h0 : 32'h0);
    src[8*32 +: 32] = 32'h0000_FFFF;
    src[9*32 +: 32] = 32'h0000_0000;
    for (int j = 0; j < 16; j++) old[j*16 +: 16] = 16'hA000 | 16'(j);
  endtask

  task automatic set_pattern(logic [31:0] seed);
    for (int j = 0; j < 16; j++) src[j*32 +: 32] = (32'h1357_9BDF * (j + 1)) ^ seed;
    for (int j = 0; j < 16; j++) old[j*16 +: 16] = 16'h5A00 | 16'(j);
  endtask

  task automatic t_reset();
    chk("reset valid R11", {511'b0, valid_o}, '0);
    chk("reset result R11", result_o, '0);
    chk("reset be R11", {480'b0, byte_en_o}, '0);
  endtask

  task automatic t_trunc();
    set_corner(); mode = 2'b00; vlen = 2'b10; mask_en = 0; mem = 0; rsvd = 4'hF;
    run("trunc R3 R2");
    chk("trunc lane4 R3", {496'b0, result_o[4*16 +: 16]}, {496'b0, 16'h0000});
  endtask

  task automatic t_ssat();
    set_corner(); mode = 2'b01; vlen = 2'b10; mask_en = 0; mem = 0;
    run("ssat R4");
    chk("ssat lane1 R4", {496'b0, result_o[1*16 +: 16]}, {496'b0, 16'h7FFF});
    chk("ssat lane3 R4", {496'b0, result_o[3*16 +: 16]}, {496'b0, 16'h8000});
    chk("ssat lane7 R4", {496'b0, result_o[7*16 +: 16]}, {496'b0, 16'hFFFF});
  endtask

  task automatic t_usat();
    set_corner(); mode = 2'b10; vlen = 2'b10; mask_en = 0; mem = 0;
    run("usat R5");
    chk("usat lane6 R5", {496'b0, result_o[6*16 +: 16]}, {496'b0, 16'hFFFF});
    chk("usat lane8 R5", {496'b0, result_o[8*16 +: 16]}, {496'b0, 16'hFFFF});
    chk("usat lane1 R5", {496'b0, result_o[1*16 +: 16]}, {496'b0, 16'h8000});
  endtask

  task automatic t_lengths();
    set_pattern(32'hC0DE_0000); mode = 2'b00; mask_en = 0; mem = 0;
    vlen = 2'b00; run("len4 R1");
    vlen = 2'b01; run("len8 R1");
    vlen = 2'b10; mode = 2'b01; run("len16 R1 R2");
  endtask

  task automatic t_merge();
    set_pattern(32'h0F0F_1234); mode = 2'b10; vlen = 2'b10; mem = 0;
    mask_en = 1; mask = 16'hA5C3; zmode = 0; run("merge R6 R7");
    chk("merge lane2 R7", {496'b0, result_o[2*16 +: 16]}, {496'b0, 16'h5A02});
    zmode = 1; run("zero R7");
    chk("zero lane2 R7", {496'b0, result_o[2*16 +: 16]}, '0);
    mask_en = 0; run("mask off R6");
  endtask

  task automatic t_mem();
    set_corner(); mode = 2'b01; vlen = 2'b01; mem = 1;
    mask_en = 1; mask = 16'h0F35; zmode = 1; run("mem R8");
    chk("mem be R8", {480'b0, byte_en_o}, {480'b0, 32'h0000_0F33});
    mem = 0; run("reg be R9");
    chk("reg be zero R9", {480'b0, byte_en_o}, '0);
  endtask

  task automatic t_illegal();
    set_pattern(32'h7777_0001); mem = 1; mask_en = 0; vlen = 2'b10; mode = 2'b00;
    rsvd = 4'hE; run("rsvd R10");
    rsvd = 4'hF; mode = 2'b11; run("mode R10");
    mode = 2'b00; vlen = 2'b11; run("vlen R10");
    vlen = 2'b10; run("legal again R10");
  endtask

  task automatic t_hold();
    logic [511:0] prev;
    prev = result_o;
    set_pattern(32'hDEAD_BEEF); mode = 2'b10; rsvd = 4'h0;
    repeat (3) @(negedge clk);
    chk("hold valid R11", {511'b0, valid_o}, '0);
    chk("hold result R11", result_o, prev);
    rsvd = 4'hF;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_trunc();
    t_ssat();
    t_usat();
    t_lengths();
    t_merge();
    t_mem();
    t_illegal();
    t_hold();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog R11 got=hung exp=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule